// File: doc/BRIEF.md
# Packet and Word Rate Limiter

This block holds back new packets on a single output port when the port has been transmitting faster than its configured budget. It keeps a debt accumulator. Every packet that is allowed to start adds a charge to the debt. The charge is a fixed per-packet cost plus a per-word cost multiplied by the packet's length in 8-byte words. The debt drains by a fixed number of credit units on every clock; the default is 16. The port may start a new packet only while the debt, divided by 256, does not exceed a configured limit.

The per-packet cost covers framing overhead that the word count leaves out: inter-frame gap, preamble and CRC, 24 bytes in all. This lets one block enforce a bit-rate limit. With the word cost set to zero, the same block enforces a packet-rate limit.

Configuration arrives on a write port. Each write carries a port tag. Only writes whose tag equals the instance's `PORT_ID` are taken. A taken write loads the new costs and limit and clears the debt.

A three-state machine drives the allow output:
- `ST_CLEAR`: no debt.
- `ST_OWING`: debt present, but within the limit.
- `ST_HELD`: debt over the limit, so starts are refused.

Every clock, the machine moves to the state that matches the next debt value:
- to `ST_HELD` when the scaled debt exceeds the limit (the charge transition);
- to `ST_OWING` when debt remains but the scaled debt is within the limit (the drain and release transitions);
- to `ST_CLEAR` when the debt reaches zero (the empty transition).

A configuration write always lands in `ST_CLEAR`.

Top module: `pkt_rate_limiter`

## Requirements
- R1: After reset the debt is zero, the cost and limit fields are zero, and `tx_allow` is 1.
- R2: A write with `cfg_we`=1 and `cfg_port`=`PORT_ID` loads the packet cost, word cost and limit, and clears the debt to zero. `tx_allow` is 1 in the following cycle.
- R3: A write whose `cfg_port` differs from `PORT_ID` changes neither the configuration nor the debt.
- R4: A start (`sop`=1 while `tx_allow`=1) adds `pkt_cost + word_cost * sop_words` to the debt, where `sop_words` counts 8-byte words.
- R5: With no charge, the debt drops by `DRAIN` (16) each cycle and stops at zero; it never wraps below zero.
- R6: `tx_allow` is 1 exactly when `debt >> 8` is less than or equal to the limit, evaluated on the debt after the clock edge.
- R7: The debt saturates at all ones (2^32-1) instead of wrapping.
- R8: `sop` asserted while `tx_allow`=0 is refused and adds no charge.
- R9: With word cost 0 (packet-rate mode), the charge is `pkt_cost` regardless of `sop_words`.
- R10: When a matching configuration write and `sop` occur in the same cycle, the write wins: the debt becomes zero and the start adds no charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | PID_W | Port tag of the write |
| cfg_pkt_cost | input | PKT_W | Credit units charged per packet |
| cfg_word_cost | input | WORD_W | Credit units charged per 8-byte word |
| cfg_limit | input | ACC_W-8 | Debt limit, in units of 256 credits |
| sop | input | 1 | Packet start request |
| sop_words | input | WCNT_W | Length of the starting packet in 8-byte words |
| tx_allow | output | 1 | High when a new packet may start |

## Verification
The bench charges a packet, then counts idle cycles until release. This catches an off-by-one in the 1/256 scaling or in the drain step, because release then comes a cycle early or late.

Each of the following is tried while the port is held, and each has a distinct wrong outcome:
- A refused start: a design that charges it stays held longer.
- A mis-tagged write: a design that accepts it releases at once.
- A write in the same cycle as a start: a design that keeps the charge is held right after the write.

Two further runs target the ends of the range. A drain to below zero must leave the port allowed, not wrap to a huge debt and hold. A run of maximum charges must saturate and hold, not wrap to a small debt and keep allowing packets.

// File: rtl/rl_pkg.sv
package rl_pkg;
    localparam int SCALE_SH = 8;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_OWING = 2'd1,
        ST_HELD  = 2'd2
    } rl_state_e;
endpackage

// File: rtl/rl_charge.sv
module rl_charge #(
    parameter int PKT_W  = 16,
    parameter int WORD_W = 16,
    parameter int WCNT_W = 12,
    parameter int CHG_W  = 29
) (
    input  logic              accept,
    input  logic [PKT_W-1:0]  pkt_cost,
    input  logic [WORD_W-1:0] word_cost,
    input  logic [WCNT_W-1:0] words,
    output logic [CHG_W-1:0]  charge
);
    logic [CHG_W-1:0] body;

    always_comb begin
        body   = CHG_W'(word_cost) * CHG_W'(words);
        charge = accept ? (CHG_W'(pkt_cost) + body) : '0;
    end
endmodule

// File: rtl/rl_debt.sv
module rl_debt #(
    parameter int ACC_W = 32,
    parameter int CHG_W = 29,
    parameter int DRAIN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CHG_W-1:0] charge,
    output logic [ACC_W-1:0] debt_q,
    output logic [ACC_W-1:0] debt_d
);
    localparam logic [ACC_W-1:0] DRAIN_V = ACC_W'(DRAIN);

    logic [ACC_W-1:0] drained;
    logic [ACC_W:0]   sum;

    generate
        if (DRAIN == 0) begin : g_nodrain
            assign drained = debt_q;
        end else begin : g_drain
            assign drained = (debt_q > DRAIN_V) ? (debt_q - DRAIN_V) : '0;
        end
    endgenerate

    always_comb begin
        sum = {1'b0, drained} + {{(ACC_W + 1 - CHG_W){1'b0}}, charge};
        if (clear)
            debt_d = '0;
        else if (sum[ACC_W])
            debt_d = '1;
        else
            debt_d = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            debt_q <= '0;
        else
            debt_q <= debt_d;
    end
endmodule

// File: rtl/pkt_rate_limiter.sv
module pkt_rate_limiter #(
    parameter int PID_W   = 6,
    parameter int PORT_ID = 5,
    parameter int PKT_W   = 16,
    parameter int WORD_W  = 16,
    parameter int WCNT_W  = 12,
    parameter int ACC_W   = 32,
    parameter int DRAIN   = 16,
    localparam int LIM_W  = ACC_W - rl_pkg::SCALE_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PID_W-1:0]  cfg_port,
    input  logic [PKT_W-1:0]  cfg_pkt_cost,
    input  logic [WORD_W-1:0] cfg_word_cost,
    input  logic [LIM_W-1:0]  cfg_limit,
    input  logic              sop,
    input  logic [WCNT_W-1:0] sop_words,
    output logic              tx_allow
);
    import rl_pkg::*;

    localparam int PROD_W = WORD_W + WCNT_W;
    localparam int CHG_W  = ((PKT_W > PROD_W) ? PKT_W : PROD_W) + 1;

    logic [PKT_W-1:0]  pkt_q;
    logic [WORD_W-1:0] word_q;
    logic [LIM_W-1:0]  lim_q;
    logic [LIM_W-1:0]  lim_d;
    logic              cfg_hit;
    logic              accept;
    logic [CHG_W-1:0]  charge;
    logic [ACC_W-1:0]  debt_q;
    logic [ACC_W-1:0]  debt_d;
    logic              over_d;
    logic              empty_d;
    rl_state_e         state_q;
    rl_state_e         state_d;

    assign cfg_hit = cfg_we && (cfg_port == PID_W'(PORT_ID));
    assign accept  = sop && tx_allow && !cfg_hit;
    assign lim_d   = cfg_hit ? cfg_limit : lim_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_q  <= '0;
            word_q <= '0;
            lim_q  <= '0;
        end else if (cfg_hit) begin
            pkt_q  <= cfg_pkt_cost;
            word_q <= cfg_word_cost;
            lim_q  <= cfg_limit;
        end
    end

    rl_charge #(
        .PKT_W (PKT_W),
        .WORD_W(WORD_W),
        .WCNT_W(WCNT_W),
        .CHG_W (CHG_W)
    ) u_charge (
        .accept   (accept),
        .pkt_cost (pkt_q),
        .word_cost(word_q),
        .words    (sop_words),
        .charge   (charge)
    );

    rl_debt #(
        .ACC_W(ACC_W),
        .CHG_W(CHG_W),
        .DRAIN(DRAIN)
    ) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cfg_hit),
        .charge(charge),
        .debt_q(debt_q),
        .debt_d(debt_d)
    );

    assign over_d  = debt_d[ACC_W-1:SCALE_SH] > lim_d;
    assign empty_d = (debt_d == '0);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (over_d)        state_d = ST_HELD;
                else if (!empty_d) state_d = ST_OWING;
                else               state_d = ST_CLEAR;
            end
            ST_OWING: begin
                if (over_d)        state_d = ST_HELD;
                else if (empty_d)  state_d = ST_CLEAR;
                else               state_d = ST_OWING;
            end
            ST_HELD: begin
                if (empty_d)       state_d = ST_CLEAR;
                else if (!over_d)  state_d = ST_OWING;
                else               state_d = ST_HELD;
            end
            default:               state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_CLEAR;
        else
            state_q <= state_d;
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_HELD: tx_allow = 1'b0;
            default: tx_allow = 1'b1;
        endcase
    end
endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
    parameter int PID_W   = 6,
    parameter int PORT_ID = 5,
    parameter int ACC_W   = 32,
    parameter int DRAIN   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [PID_W-1:0] cfg_port,
    input logic             sop,
    input logic             tx_allow,
    input logic [ACC_W-1:0] debt
);
    logic hit;
    assign hit = cfg_we && (cfg_port == PID_W'(PORT_ID));

    assert_cfg_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (debt == '0) && tx_allow);

    assert_foreign_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !hit && !sop) |=> (debt <= $past(debt)));

    assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((DRAIN > 0) && (debt != '0) && !sop && !hit) |=> (debt < $past(debt)));

    assert_hold_only_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_allow) |-> $past(sop));

    assert_refused_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sop && !tx_allow && !hit) |=> (debt <= $past(debt)));
endmodule

bind pkt_rate_limiter rl_checker #(
    .PID_W  (PID_W),
    .PORT_ID(PORT_ID),
    .ACC_W  (ACC_W),
    .DRAIN  (DRAIN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_port(cfg_port),
    .sop     (sop),
    .tx_allow(tx_allow),
    .debt    (debt_q)
);

// File: tb/pkt_rate_limiter_tb.sv
module pkt_rate_limiter_tb;
    localparam int ID = 5;

    typedef struct {
        bit    exp;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_port = '0;
    logic [15:0] cfg_pkt_cost = '0;
    logic [15:0] cfg_word_cost = '0;
    logic [23:0] cfg_limit = '0;
    logic        sop = 1'b0;
    logic [11:0] sop_words = '0;
    logic        tx_allow;

    int checks = 0;
    int fails = 0;
    exp_t q[$];

    longint m_acc = 0;
    longint m_pkt = 0;
    longint m_word = 0;
    longint m_lim = 0;
    bit     m_allow = 1'b1;

    always #4 clk = ~clk;

    pkt_rate_limiter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
        .cfg_pkt_cost(cfg_pkt_cost), .cfg_word_cost(cfg_word_cost),
        .cfg_limit(cfg_limit), .sop(sop), .sop_words(sop_words),
        .tx_allow(tx_allow)
    );

    task automatic step(input bit we, input int port, input int pk, input int wd,
                        input int lim, input bit s, input int wc, input string tag);
        longint chg;
        @(negedge clk);
        cfg_we        = we;
        cfg_port      = 6'(port);
        cfg_pkt_cost  = 16'(pk);
        cfg_word_cost = 16'(wd);
        cfg_limit     = 24'(lim);
        sop           = s;
        sop_words     = 12'(wc);
        if (we && port == ID) begin
            m_acc = 0; m_pkt = pk; m_word = wd; m_lim = lim;
        end else begin
            chg   = (s && m_allow) ? (m_pkt + m_word * wc) : 0;
            m_acc = ((m_acc > 16) ? (m_acc - 16) : 0) + chg;
            if (m_acc > 64'hFFFF_FFFF) m_acc = 64'hFFFF_FFFF;
        end
        m_allow = ((m_acc >> 8) <= m_lim);
        q.push_back('{m_allow, tag});
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                checks++;
                if (tx_allow !== it.exp) begin
                    fails++;
                    $display("FAIL %s: tx_allow=%0b expected %0b", it.tag, tx_allow, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (tx_allow !== 1'b1) begin
            fails++;
            $display("FAIL R1: tx_allow=%0b expected 1", tx_allow);
        end
        rst_n = 1'b1;

        // R2 load config: pkt 768, word 256, limit 2
        step(1, ID, 768, 256, 2, 0, 0, "R2");
        // R4 one-word packet charges 1024, held
        step(0, 0, 0, 0, 0, 1, 1, "R4");
        // R6 release after scaled debt falls to limit
        idle(18, "R6");
        // charge again, then foreign write must not release
        step(0, 0, 0, 0, 0, 1, 1, "R4");
        step(1, 9, 0, 0, 24'hFFFFFF, 0, 0, "R3");
        idle(2, "R3");
        // R8 refused starts while held
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 1, "R8");
        idle(14, "R8");
        // R10 write and start together: write wins
        step(1, ID, 768, 256, 2, 1, 1, "R10");
        idle(2, "R10");
        // R4 word multiply: 8 words * 64 = 512 > limit 1
        step(1, ID, 0, 64, 1, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 1, 8, "R4");
        idle(3, "R4");
        step(1, ID, 0, 64, 1, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 1, 4, "R4");
        idle(2, "R4");
        // R9 packet-rate mode, then R5 floor at zero
        step(1, ID, 300, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 1, 4095, "R9");
        idle(4, "R9");
        idle(10, "R5");
        // R7 saturation
        step(1, ID, 65535, 65535, 24'hFFFFFE, 0, 0, "R2");
        for (int i = 0; i < 18; i++) step(0, 0, 0, 0, 0, 1, 4095, "R7");
        idle(20, "R7");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule